// File: doc/BRIEF.md
# Rate Strobe Generator

This block derives a slower event rate from a fast system clock without creating a second clock. Every N cycles it raises a one-cycle enable strobe. Flip-flops in the slow part of a design can use this strobe as their clock enable. The strobe can also drive the enable pin of a clock-gating buffer that is fed from the same ungated clock. The counter runs on that same ungated clock, so gated and ungated logic stay edge-aligned. The strobe comes straight from a flip-flop, so no counter decode glitch or decode delay reaches the output.

A run-time select forces the strobe permanently high, and the downstream logic then runs on every cycle. A divisor of 0 or 1 gives the same full-rate behaviour. The divisor is read only at the start of each period. Changing it while a period is in progress therefore never produces a short period. The period is exactly the divisor value: the terminal count is one below the divisor.

Top module: `rate_strobe_gen`

## Requirements
- R1: With full_rate_i = 0 and a stable divisor N >= 2, en_o is high for exactly one cycle. Consecutive strobes are exactly N rising edges apart, and the counter is at zero in every cycle en_o is high.
- R2: After every rising edge at which full_rate_i is sampled 1, en_o is high for the following cycle.
- R3: With full_rate_i = 0 and a divisor of 0 or 1 sampled at a period start, en_o is high every cycle, as in full-rate mode.
- R4: While rst_ni is low, en_o is 0. Asserting reset forces en_o low at once, without waiting for a clock edge. After reset is released, en_o first goes high after the N-th rising edge.
- R5: On a switch from full rate to divided mode, en_o is low after the first edge at which full_rate_i is sampled 0. The first divided strobe follows the N-th edge counted from that edge.
- R6: The divisor is captured at the edge that opens a period, which is the edge after a strobe or any edge while the counter is idle at zero. A divisor change in mid-period lets the current period finish at its old length, and the new length applies from the next period.
- R7: en_o changes only at rising clock edges or on reset assertion. A change on full_rate_i or divisor_i between edges leaves en_o unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast ungated system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| full_rate_i | input | 1 | 1 = enable held high every cycle, 0 = divided mode |
| divisor_i | input | 16 | Strobe period in cycles; 0 or 1 means full rate |
| en_o | output | 1 | Registered clock-enable strobe |

## Verification
The hardest case to reach from the ports is a divisor change that lands inside a running period, because the capture point is hidden behind the strobe. The stimulus waits a known number of edges after a strobe, changes the divisor mid-cycle, and then expects one strobe at the old spacing followed by strobes at the new spacing. The return from bypass is reached in a similar way: the divisor is loaded while full rate is held, and the first divided strobe is timed from the edge that drops the select.

// File: rtl/rate_strobe_pkg.sv
package rate_strobe_pkg;
  localparam int unsigned DIV_W_DEF = 16;

  typedef enum logic {
    RATE_DIVIDED = 1'b0,
    RATE_FULL    = 1'b1
  } rate_sel_e;
endpackage

// File: rtl/rsg_period_sel.sv
// Captures the period length at each period start; flags lengths that mean full rate.
module rsg_period_sel #(
  parameter int unsigned DIV_W = rate_strobe_pkg::DIV_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic [DIV_W-1:0] len_o,
  output logic             short_o
);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  logic [DIV_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      len_q <= '0;
    else if (start_i) len_q <= divisor_i;
  end

  // the live divisor applies on the opening edge of a period
  assign len_o   = start_i ? divisor_i : len_q;
  assign short_o = (len_o < MIN_DIV);
endmodule

// File: rtl/rsg_counter.sv
module rsg_counter #(
  parameter int unsigned DIV_W = rate_strobe_pkg::DIV_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic [DIV_W-1:0] len_i,
  output logic             zero_o,
  output logic             wrap_o,
  output logic [DIV_W-1:0] cnt_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last_c;

  // terminal count one below the length: period equals the divisor exactly
  assign last_c = len_i - ONE;
  assign wrap_o = !hold_i && (cnt_q >= last_c);
  assign zero_o = (cnt_q == '0);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (hold_i || wrap_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/rsg_strobe_reg.sv
module rsg_strobe_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic wrap_i,
  output logic en_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= hold_i | wrap_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/rate_strobe_gen.sv
module rate_strobe_gen #(
  parameter int unsigned DIV_W = rate_strobe_pkg::DIV_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             full_rate_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             en_o
);
  import rate_strobe_pkg::*;

  logic             cnt_zero;
  logic             cnt_wrap;
  logic             len_short;
  logic             hold;
  logic [DIV_W-1:0] len;
  logic [DIV_W-1:0] cnt_q;
  rate_sel_e        sel;

  assign sel  = rate_sel_e'(full_rate_i);
  assign hold = (sel == RATE_FULL) || len_short;

  rsg_period_sel #(.DIV_W(DIV_W)) u_period (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (cnt_zero),
    .divisor_i (divisor_i),
    .len_o     (len),
    .short_o   (len_short)
  );

  rsg_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold),
    .len_i  (len),
    .zero_o (cnt_zero),
    .wrap_o (cnt_wrap),
    .cnt_o  (cnt_q)
  );

  rsg_strobe_reg u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold),
    .wrap_i (cnt_wrap),
    .en_o   (en_o)
  );
endmodule

// File: rtl/rate_strobe_gen_chk.sv
module rate_strobe_gen_chk #(
  parameter int unsigned DIV_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             full_rate_i,
  input logic [DIV_W-1:0] divisor_i,
  input logic             en_o,
  input logic [DIV_W-1:0] cnt_i
);
  assert_full_rate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_rate_i |=> en_o);

  assert_single_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && !full_rate_i && divisor_i >= DIV_W'(2)) |=> !en_o);

  assert_strobe_at_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> (cnt_i == '0));

  assert_short_div_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_rate_i && divisor_i < DIV_W'(2) && cnt_i == '0) |=> en_o);

  assert_leave_bypass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(full_rate_i) && !full_rate_i && divisor_i >= DIV_W'(2)) |=> !en_o);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_low_R4: assert (!en_o && cnt_i == '0);
    end
  end
endmodule

bind rate_strobe_gen rate_strobe_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .full_rate_i (full_rate_i),
  .divisor_i   (divisor_i),
  .en_o        (en_o),
  .cnt_i       (cnt_q)
);

// File: tb/tb_rate_strobe_gen.sv
module tb_rate_strobe_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NVEC = 8;
  // {full_rate, divisor}
  localparam logic [DW:0] VEC [NVEC] = '{
    {1'b0, 16'd2}, {1'b0, 16'd3}, {1'b0, 16'd7}, {1'b0, 16'd250},
    {1'b1, 16'd250}, {1'b0, 16'd0}, {1'b0, 16'd1}, {1'b1, 16'd5}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          full_rate_i = 1'b0;
  logic [DW-1:0] divisor_i = 16'd4;
  logic          en_o;
  int checks = 0;
  int failures = 0;

  rate_strobe_gen #(.DIV_W(DW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .full_rate_i(full_rate_i),
    .divisor_i(divisor_i), .en_o(en_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s en_o actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    step();
    step();
    rst_ni = 1'b1;
  endtask

  // walks n_edges edges; edge j expects high if hi or (j+phase)%n==0
  task automatic run_expect(input string req, input int n_edges, input int n,
                            input int phase, input bit hi);
    bit bad = 0;
    checks++;
    for (int j = 1; j <= n_edges; j++) begin
      logic exp_v;
      step();
      exp_v = hi || (n >= 2 && ((j + phase) % n) == 0);
      if (!bad && en_o !== exp_v) begin
        bad = 1;
        failures++;
        $display("FAIL %s edge=%0d en_o actual=%0b expected=%0b", req, j, en_o, exp_v);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // reset state R4
    step();
    chk("R4 reset", en_o, 1'b0);

    // vector walk: R1 spacing/width, R2 bypass, R3 short divisor, R4 first strobe
    for (int v = 0; v < NVEC; v++) begin
      int n;
      bit hi;
      full_rate_i = VEC[v][DW];
      divisor_i   = VEC[v][DW-1:0];
      n  = int'(VEC[v][DW-1:0]);
      hi = VEC[v][DW] || n < 2;
      do_reset();
      run_expect(VEC[v][DW] ? "R2 vec" : (n < 2 ? "R3 vec" : "R1/R4 vec"),
                 (n < 2 ? 8 : 3 * n + 2), n, 0, hi);
    end

    // R5: leave bypass with divisor 4 preloaded
    full_rate_i = 1'b1; divisor_i = 16'd4;
    do_reset();
    run_expect("R2 hold", 5, 4, 0, 1'b1);
    full_rate_i = 1'b0;
    run_expect("R5 switch", 12, 4, 0, 1'b0);

    // R6: change 5 -> 3 two edges into a period
    divisor_i = 16'd5;
    do_reset();
    run_expect("R6 old len", 7, 5, 0, 1'b0);
    divisor_i = 16'd3;
    run_expect("R6 finish old", 3, 5, 7, 1'b0);
    run_expect("R6 new len", 7, 3, 0, 1'b0);

    // R7: mid-cycle input changes do not move en_o
    divisor_i = 16'd4;
    do_reset();
    step(); step();
    full_rate_i = 1'b1;
    #3;
    chk("R7 hold low", en_o, 1'b0);
    step();
    chk("R2 after edge", en_o, 1'b1);
    full_rate_i = 1'b0; divisor_i = 16'd9;
    #3;
    chk("R7 hold high", en_o, 1'b1);
    step();
    chk("R5 first low", en_o, 1'b0);

    // R4: asynchronous reset while bypassed, then restart count
    full_rate_i = 1'b1;
    step();
    chk("R2 pre-reset", en_o, 1'b1);
    rst_ni = 1'b0;
    #1;
    chk("R4 async clear", en_o, 1'b0);
    full_rate_i = 1'b0; divisor_i = 16'd6;
    step();
    rst_ni = 1'b1;
    run_expect("R4 restart", 14, 6, 0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule